// File: doc/BRIEF.md
# Two-Vector Testable Controlled-Swap D Latch

This block is a level-sensitive D latch built from two cascaded three-input controlled-swap cells. The first cell forms the next state from the data input, the enable and the fed-back state. The second cell makes copies of that next state, so no net fans out directly. One copy drives the output and another closes the feedback loop. Two mode inputs, `c1` and `c2`, program the second cell. With one setting the loop is closed and the block acts as an ordinary latch. With the two test settings the loop is forced to a constant. Applying an all-ones or an all-zeros vector then drives every cell output to that constant, and any unidirectional stuck-at fault shows as a mismatch.

The storage of the loop is a register sampled on `clk`. The output is transparent within a cycle while the enable is active and holds the stored value otherwise. A parameter selects positive or negative enable polarity. All six cell outputs are brought out. A fault-injection hook, present when `FAULT_HOOK` is set, can force any one of them to a stuck value so that a bench can confirm every single fault is caught.

Top module: `rev_test_dlatch`

## Requirements
- R1: After reset the stored state is 0. With the enable inactive and normal mode selected, `q` reads 0.
- R2: With `NEG_ENABLE`=0 and normal mode (`c1`=0, `c2`=1), `q` equals `d` in the same cycle while `en`=1. While `en`=0, `q` keeps the value stored at the last rising clock edge, whatever `d` does.
- R3: With `NEG_ENABLE`=1 the polarity is inverted. `q` follows `d` while `en`=0 and holds while `en`=1.
- R4: Each cell is conservative: the number of 1s on its three outputs equals the number of 1s on its three inputs. The first cell takes (`en`, state, `d`) and the second takes (next state, `c1`, `c2`). A control of 1 swaps the two data inputs.
- R5: `gate_out` bit order is [0] cell1 control copy, [1] cell1 first data output, [2] cell1 second data output, [3] cell2 control copy, [4] cell2 first data output (the feedback copy), [5] cell2 second data output. In normal mode without faults, bits 3 and 4 both equal the next state and bit 5 is its inverse.
- R6: All-ones test: `c1`=`c2`=`d`=`en`=1 held for two cycles drives all six `gate_out` bits to 1 in the second cycle, with `test_fail`=0.
- R7: All-zeros test: `c1`=`c2`=`d`=`en`=0 held for two cycles drives all six `gate_out` bits to 0 in the second cycle, with `test_fail`=0.
- R8: When `fault_en`=1, the net indexed by `fault_sel` (same numbering as `gate_out`) is forced to `fault_val`. Every stuck-at-0 fault raises `test_fail` in the second cycle of the all-ones vector, and every stuck-at-1 fault raises it in the second cycle of the all-zeros vector. A fault whose stuck value equals the applied constant does not raise it.
- R9: `mode_error` is 1 exactly when `c1`=1 and `c2`=0.
- R10: `test_fail` is 0 outside test modes, and it is 0 in the first cycle after a test mode is entered or changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling the loop storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | 1 | Data input |
| en | input | 1 | Enable, polarity set by NEG_ENABLE |
| c1 | input | 1 | Mode control, data input A of cell 2 |
| c2 | input | 1 | Mode control, data input B of cell 2 |
| fault_en | input | 1 | Enables fault injection |
| fault_sel | input | 3 | Index of the net to force |
| fault_val | input | 1 | Stuck value forced onto the selected net |
| q | output | 1 | Latch output |
| gate_out | output | 6 | All cell outputs, order per R5 |
| test_fail | output | 1 | Settled test mode with an output off the applied constant |
| mode_error | output | 1 | Undefined control pair applied |

## Verification
`q`, `gate_out` and `mode_error` are combinational, so each is due in the same cycle in which its inputs are applied. The stored state moves at the next rising edge. `test_fail` is only meaningful from the second cycle of an unchanged test vector. The driver applies every stimulus on a falling edge and computes the expected item from its own model of the stored state and the previous mode, which it advances once per rising edge. The monitor compares that item 2 ns after the same falling edge, before the next rising edge can move anything.

// File: rtl/rev_latch_pkg.sv
package rev_latch_pkg;
  localparam int unsigned NETS_PER_CELL = 3;
  localparam int unsigned CELL_COUNT    = 2;
  localparam int unsigned NET_COUNT     = NETS_PER_CELL * CELL_COUNT;
  localparam int unsigned SEL_W         = $clog2(NET_COUNT);

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ONES   = 2'd1,
    MODE_ZEROS  = 2'd2,
    MODE_BAD    = 2'd3
  } mode_e;

  typedef struct packed {
    logic r;
    logic q;
    logic p;
  } triple_t;

  // controlled swap: control of 1 exchanges the two data lines
  function automatic triple_t cswap(input logic a, input logic b, input logic c);
    triple_t t;
    t.p = a;
    t.q = a ? c : b;
    t.r = a ? b : c;
    return t;
  endfunction

  function automatic mode_e decode_mode(input logic c1, input logic c2);
    case ({c1, c2})
      2'b01:   return MODE_NORMAL;
      2'b11:   return MODE_ONES;
      2'b00:   return MODE_ZEROS;
      default: return MODE_BAD;
    endcase
  endfunction

  function automatic logic mode_is_test(input mode_e m);
    return (m == MODE_ONES) || (m == MODE_ZEROS);
  endfunction
endpackage

// File: rtl/cswap_cell.sv
module cswap_cell
  import rev_latch_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic [NETS_PER_CELL-1:0] y
);
  triple_t t;
  always_comb t = cswap(a, b, c);
  assign y = {t.r, t.q, t.p};
endmodule

// File: rtl/net_fault_tap.sv
module net_fault_tap #(
  parameter bit HOOK = 1'b1
) (
  input  logic net_in,
  input  logic hit,
  input  logic stuck,
  output logic net_out
);
  generate
    if (HOOK) begin : g_hook
      assign net_out = hit ? stuck : net_in;
    end else begin : g_pass
      logic unused_tie;
      assign unused_tie = hit ^ stuck;
      assign net_out    = net_in;
    end
  endgenerate
endmodule

// File: rtl/latch_mode_decode.sv
module latch_mode_decode
  import rev_latch_pkg::*;
(
  input  logic  c1,
  input  logic  c2,
  output mode_e mode,
  output logic  test_active,
  output logic  test_level,
  output logic  bad
);
  always_comb begin
    mode        = decode_mode(c1, c2);
    test_active = mode_is_test(mode);
    test_level  = (mode == MODE_ONES);
    bad         = (mode == MODE_BAD);
  end
endmodule

// File: rtl/rev_test_dlatch.sv
module rev_test_dlatch
  import rev_latch_pkg::*;
#(
  parameter bit NEG_ENABLE = 1'b0,
  parameter bit FAULT_HOOK = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d,
  input  logic                 en,
  input  logic                 c1,
  input  logic                 c2,
  input  logic                 fault_en,
  input  logic [SEL_W-1:0]     fault_sel,
  input  logic                 fault_val,
  output logic                 q,
  output logic [NET_COUNT-1:0] gate_out,
  output logic                 test_fail,
  output logic                 mode_error
);
  logic                     state_q;
  logic [NETS_PER_CELL-1:0] g1_raw, g1_f, g2_raw, g2_f;
  logic                     next_state;
  mode_e                    mode_now, mode_q;
  logic                     test_active, test_level, bad_pair;
  logic                     settled;
  logic [NET_COUNT-1:0]     mismatch;

  // cell 1: control = enable, data = (stored state, d)
  cswap_cell u_cell1 (.a(en), .b(state_q), .c(d), .y(g1_raw));

  for (genvar i = 0; i < NETS_PER_CELL; i++) begin : g_tap1
    net_fault_tap #(.HOOK(FAULT_HOOK)) u_tap (
      .net_in (g1_raw[i]),
      .hit    (fault_en && (fault_sel == SEL_W'(i))),
      .stuck  (fault_val),
      .net_out(g1_f[i])
    );
  end

  generate
    if (NEG_ENABLE) begin : g_neg
      assign next_state = g1_f[2];
    end else begin : g_pos
      assign next_state = g1_f[1];
    end
  endgenerate

  // cell 2: fan-out copy of the next state, controls break the loop in test
  cswap_cell u_cell2 (.a(next_state), .b(c1), .c(c2), .y(g2_raw));

  for (genvar i = 0; i < NETS_PER_CELL; i++) begin : g_tap2
    net_fault_tap #(.HOOK(FAULT_HOOK)) u_tap (
      .net_in (g2_raw[i]),
      .hit    (fault_en && (fault_sel == SEL_W'(i + NETS_PER_CELL))),
      .stuck  (fault_val),
      .net_out(g2_f[i])
    );
  end

  latch_mode_decode u_mode (
    .c1(c1), .c2(c2), .mode(mode_now),
    .test_active(test_active), .test_level(test_level), .bad(bad_pair)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      mode_q  <= MODE_NORMAL;
    end else begin
      state_q <= g2_f[1];
      mode_q  <= mode_now;
    end
  end

  assign gate_out   = {g2_f, g1_f};
  assign q          = g2_f[0];
  assign settled    = test_active && (mode_now == mode_q);
  assign mismatch   = gate_out ^ {NET_COUNT{test_level}};
  assign test_fail  = settled && (|mismatch);
  assign mode_error = bad_pair;
endmodule

// File: rtl/rev_test_dlatch_chk.sv
module rev_test_dlatch_chk #(
  parameter bit NEG_ENABLE = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       d,
  input logic       en,
  input logic       c1,
  input logic       c2,
  input logic       fault_en,
  input logic       fault_val,
  input logic       q,
  input logic [5:0] gate_out,
  input logic       test_fail,
  input logic       mode_error,
  input logic [2:0] g1_in,
  input logic [2:0] g1_out,
  input logic [2:0] g2_in,
  input logic [2:0] g2_out
);
  logic en_hold, prev_hold, prev_ones, prev_zeros;
  assign en_hold = NEG_ENABLE ? en : !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hold  <= 1'b0;
      prev_ones  <= 1'b0;
      prev_zeros <= 1'b0;
    end else begin
      prev_hold  <= !c1 && c2 && en_hold && !fault_en;
      prev_ones  <= c1 && c2;
      prev_zeros <= !c1 && !c2;
    end
  end

  a_r4_cell1_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g1_in) == $countones(g1_out));
  a_r4_cell2_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g2_in) == $countones(g2_out));
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_hold && !c1 && c2 && en_hold && !fault_en) |-> $stable(q));
  a_r5_copy_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1 && c2 && !fault_en) |-> (gate_out[3] == gate_out[4]) && (gate_out[5] != gate_out[3]));
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ones && c1 && c2 && d && en && !fault_en) |-> (gate_out == 6'h3f) && !test_fail);
  a_r7_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_zeros && !c1 && !c2 && !d && !en && !fault_en) |-> (gate_out == 6'h00) && !test_fail);
  a_r8_sa0_caught: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ones && c1 && c2 && d && en && fault_en && !fault_val) |-> test_fail);
  a_r9_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |-> (c1 && !c2));
  a_r9_good_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (c2 || !c1) |-> !mode_error);
  a_r10_quiet_outside_test: assert property (@(posedge clk) disable iff (!rst_n)
    (c1 != c2) |-> !test_fail);
endmodule

bind rev_test_dlatch rev_test_dlatch_chk #(.NEG_ENABLE(NEG_ENABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .d(d), .en(en), .c1(c1), .c2(c2),
  .fault_en(fault_en), .fault_val(fault_val), .q(q), .gate_out(gate_out),
  .test_fail(test_fail), .mode_error(mode_error),
  .g1_in({d, state_q, en}), .g1_out(g1_raw),
  .g2_in({c2, c1, next_state}), .g2_out(g2_raw)
);

// File: tb/rev_test_dlatch_tb_top.sv
`timescale 1ns/1ps
module rev_test_dlatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d = 0, en = 0, c1 = 0, c2 = 1, fault_en = 0, fault_val = 0;
  logic [2:0] fault_sel = 3'd0;
  logic       q_p, q_n, tf_p, tf_n, me_p, me_n;
  logic [5:0] go_p, go_n;

  always #5 clk = ~clk;

  rev_test_dlatch #(.NEG_ENABLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .d(d), .en(en), .c1(c1), .c2(c2),
    .fault_en(fault_en), .fault_sel(fault_sel), .fault_val(fault_val),
    .q(q_p), .gate_out(go_p), .test_fail(tf_p), .mode_error(me_p));

  rev_test_dlatch #(.NEG_ENABLE(1'b1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .d(d), .en(en), .c1(c1), .c2(c2),
    .fault_en(fault_en), .fault_sel(fault_sel), .fault_val(fault_val),
    .q(q_n), .gate_out(go_n), .test_fail(tf_n), .mode_error(me_n));

  typedef struct {
    logic       q;
    logic [5:0] go;
    logic       tf;
    logic       me;
  } obs_t;

  typedef struct {
    obs_t  p;
    obs_t  n;
    string tag_p;
    string tag_n;
  } item_t;

  item_t sb[$];
  int    n_checks = 0;
  int    n_fail = 0;
  logic  st_p = 0, st_n = 0;
  logic [1:0] prev_ctl = 2'b01;
  bit    done = 0;

  // bench's own view of a controlled swap, written as sums of products
  function automatic logic [2:0] sw(input logic a, input logic b, input logic c);
    logic o1, o2;
    o1 = (!a & b) | (a & c);
    o2 = (!a & c) | (a & b);
    return {o2, o1, a};
  endfunction

  function automatic logic [5:0] force_net(input logic [5:0] v, input int idx,
                                           input logic fe, input int sel, input logic fv);
    logic [5:0] r;
    r = v;
    if (fe && sel == idx) r[idx] = fv;
    return r;
  endfunction

  function automatic obs_t model(input bit neg, input logic st, input logic dd, input logic ee,
                                 input logic k1, input logic k2, input logic fe, input int sel,
                                 input logic fv, input logic [1:0] pctl, output logic nxt);
    obs_t o;
    logic [5:0] nets;
    logic ns, lvl, tst;
    nets = 6'd0;
    nets[2:0] = sw(ee, st, dd);
    for (int i = 0; i < 3; i++) nets = force_net(nets, i, fe, sel, fv);
    ns = neg ? nets[2] : nets[1];
    nets[5:3] = sw(ns, k1, k2);
    for (int i = 3; i < 6; i++) nets = force_net(nets, i, fe, sel, fv);
    nxt  = nets[4];
    tst  = (k1 == k2);
    lvl  = k1;
    o.q  = nets[3];
    o.go = nets;
    o.me = k1 & !k2;
    o.tf = tst && ({k1, k2} == pctl) && (nets != {6{lvl}});
    return o;
  endfunction

  task automatic step(input logic dd, input logic ee, input logic k1, input logic k2,
                      input logic fe, input int sel, input logic fv,
                      input string tp, input string tn);
    item_t it;
    logic np, nn;
    @(negedge clk);
    d = dd; en = ee; c1 = k1; c2 = k2;
    fault_en = fe; fault_sel = 3'(sel); fault_val = fv;
    it.p = model(1'b0, st_p, dd, ee, k1, k2, fe, sel, fv, prev_ctl, np);
    it.n = model(1'b1, st_n, dd, ee, k1, k2, fe, sel, fv, prev_ctl, nn);
    it.tag_p = tp;
    it.tag_n = tn;
    sb.push_back(it);
    st_p = np;
    st_n = nn;
    prev_ctl = {k1, k2};
  endtask

  task automatic cmp(input string tag, input string who, input string fld,
                     input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s %s: actual %b expected %b", tag, who, fld, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        cmp(it.tag_p, "pos", "q",          {5'd0, q_p},  {5'd0, it.p.q});
        cmp(it.tag_p, "pos", "gate_out",   go_p,         it.p.go);
        cmp(it.tag_p, "pos", "test_fail",  {5'd0, tf_p}, {5'd0, it.p.tf});
        cmp(it.tag_p, "pos", "mode_error", {5'd0, me_p}, {5'd0, it.p.me});
        cmp(it.tag_n, "neg", "q",          {5'd0, q_n},  {5'd0, it.n.q});
        cmp(it.tag_n, "neg", "gate_out",   go_n,         it.n.go);
        cmp(it.tag_n, "neg", "test_fail",  {5'd0, tf_n}, {5'd0, it.n.tf});
        cmp(it.tag_n, "neg", "mode_error", {5'd0, me_n}, {5'd0, it.n.me});
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, enable inactive for the positive copy
    step(0, 0, 0, 1, 0, 0, 0, "R1", "R3");
    step(1, 0, 0, 1, 0, 0, 0, "R1", "R3");
    // R2 and R3: transparency and hold in normal mode, R5 on every item
    step(1, 1, 0, 1, 0, 0, 0, "R2", "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R2", "R3");
    step(1, 0, 0, 1, 0, 0, 0, "R2", "R3");
    step(0, 1, 0, 1, 0, 0, 0, "R2", "R3");
    step(1, 1, 0, 1, 0, 0, 0, "R2", "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R5", "R5");
    step(1, 1, 0, 1, 0, 0, 0, "R5", "R5");
    // R6: all-ones, first cycle unsettled (R10) then settled
    step(1, 1, 1, 1, 0, 0, 0, "R10", "R10");
    step(1, 1, 1, 1, 0, 0, 0, "R6", "R6");
    // R7: all-zeros
    step(0, 0, 0, 0, 0, 0, 0, "R10", "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R7", "R7");
    // R8: every net, both stuck values, under both vectors
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 1, 1, 1, i, 0, "R10", "R10");
      step(1, 1, 1, 1, 1, i, 0, "R8", "R8");
      step(1, 1, 1, 1, 1, i, 1, "R8", "R8");
      step(0, 0, 0, 0, 1, i, 1, "R10", "R10");
      step(0, 0, 0, 0, 1, i, 1, "R8", "R8");
      step(0, 0, 0, 0, 1, i, 0, "R8", "R8");
    end
    // R9: undefined pair and back to normal
    step(1, 1, 1, 0, 0, 0, 0, "R9", "R9");
    step(0, 0, 1, 0, 0, 0, 0, "R9", "R9");
    step(1, 1, 0, 1, 0, 0, 0, "R9", "R9");
    step(0, 0, 0, 1, 0, 0, 0, "R2", "R3");
    step(1, 0, 0, 1, 0, 0, 0, "R2", "R3");
    step(1, 1, 0, 1, 1, 3, 0, "R10", "R10");
    step(0, 0, 0, 1, 0, 0, 0, "R2", "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule